// File: doc/BRIEF.md
# External Data Memory Wait-State Generator

This block stretches CPU data accesses that land in the upper, external part of the data address space. The CPU presents an address together with a one-cycle start strobe. If the address is in the external window, the block holds a stall output high for a programmed number of cycles. It then signals completion with a one-cycle done pulse. Accesses below the window complete in the next cycle with no stall.

The number of inserted cycles comes from a 2-bit code held in a 16-bit control register, which has its own write port. The code selects 0, 1, 3 or 7 cycles. A slow external device can lengthen any external access further by holding an asynchronous wait input high. That input is resynchronised before the block uses it. The memory bus itself lies outside this block. The block only decides when the CPU may proceed.

Top module: `xmem_wait_gen`

## Requirements
- R1: After reset the control register reads 16'h0003, so the code selects 7 wait cycles. Stall and done are both low.
- R2: A write stores all 16 bits of regWrData. The value appears on regRdData in the cycle after the write edge.
- R3: An access to an address below 16'hC000 completes with accDone high in the cycle after the start edge. cpuStall stays low, whatever the wait code or the wait pin holds.
- R4: With waitPin low, an external access stalls for exactly N cycles, where the code in register bits [1:0] gives 00→0, 01→1, 10→3, 11→7. accDone is high in the cycle after the last stall cycle, N+1 cycles after the start edge.
- R5: Addresses 16'hC000 and 16'hFFFF are external. Address 16'hBFFF is not.
- R6: The wait pin passes through two flip-flops before use. An external access never completes while the synchronised wait is high at the point where the count has expired. After waitPin falls, accDone follows on the third rising edge.
- R7: A start strobe that arrives while an access is stalled is ignored. It neither produces a second done pulse nor changes the running access.
- R8: The wait count is captured when an access starts. A register write during a stalled access does not change that access's length, but it does apply to the next access.
- R9: accDone is never high in the same cycle as cpuStall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accAddr | input | 16 | CPU data address, sampled with accStart |
| accStart | input | 1 | One-cycle strobe that begins an access |
| cpuStall | output | 1 | High while the CPU must hold the current access |
| accDone | output | 1 | One-cycle pulse when the access completes |
| regWrEn | input | 1 | Control register write enable |
| regWrData | input | 16 | Control register write data |
| regRdData | output | 16 | Current control register contents |
| waitPin | input | 1 | Asynchronous external wait request, active high |

## Verification
All inputs are driven on falling edges and all outputs are sampled on falling edges. Each result is therefore read exactly one rising edge after the cause that should produce it.

A completed access shows accDone at sample N+1 after the start sample, with cpuStall high at samples 1 through N. A register write is visible at the first sample after its edge.

When the wait pin is released, two synchroniser flops and the controller register lie on the path. accDone is therefore expected at the third sample after the release, with stall still high at the first two. The bench counts samples against these fixed offsets rather than waiting loosely for an event.

// File: rtl/xmem_wait_pkg.sv
package xmem_wait_pkg;

  // Controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } waitState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } ctrlStrobe_t;

endpackage

// File: rtl/xmem_wait_dp.sv
module xmem_wait_dp
  import xmem_wait_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 16,
  parameter int CODE_W      = 2,
  parameter int CODE_LSB    = 0,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'hC000,
  parameter logic [CODE_W-1:0] RST_CODE = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              waitPin,
  input  ctrlStrobe_t       strobe,
  output logic [REG_W-1:0]  regQ,
  output logic              isExt,
  output logic              loadZero,
  output logic              cntIsOne,
  output logic              waitSync
);

  // Largest count is 2^(2^CODE_W - 1) - 1, so this many bits hold it
  localparam int CNT_W = (1 << CODE_W) - 1;
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(RST_CODE) << CODE_LSB;

  logic [CODE_W-1:0] codeField;
  logic [CNT_W:0]    loadWide;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  cntQ;
  logic [SYNC_STAGES-1:0] syncQ;

  // Control register
  always_ff @(posedge clk) begin
    if (!rstN) regQ <= RST_VAL;
    else if (regWrEn) regQ <= regWrData;
  end

  assign codeField = regQ[CODE_LSB +: CODE_W];

  // code c selects (2^c) - 1 wait cycles
  always_comb begin
    loadWide = ({{CNT_W{1'b0}}, 1'b1} << codeField) - {{CNT_W{1'b0}}, 1'b1};
    loadVal  = loadWide[CNT_W-1:0];
  end

  assign loadZero = (loadVal == '0);
  assign isExt    = (accAddr >= EXT_BASE);

  // Wait-pin synchroniser chain
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= waitPin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign waitSync = syncQ[SYNC_STAGES-1];

  // Wait counter
  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= loadVal;
    else if (strobe.decCnt)  cntQ <= cntQ - 1'b1;
  end

  assign cntIsOne = (cntQ == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/xmem_wait_ctrl.sv
module xmem_wait_ctrl
  import xmem_wait_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accStart,
  input  logic        isExt,
  input  logic        loadZero,
  input  logic        cntIsOne,
  input  logic        waitSync,
  output ctrlStrobe_t strobe,
  output logic        cpuStall,
  output logic        accDone
);

  waitState_e stateQ, stateNext;
  logic       doneNext;

  always_comb begin
    stateNext      = stateQ;
    doneNext       = 1'b0;
    strobe.loadCnt = 1'b0;
    strobe.decCnt  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (accStart) begin
          if (!isExt) begin
            doneNext = 1'b1;
          end else if (loadZero) begin
            if (waitSync) stateNext = ST_HOLD;
            else          doneNext  = 1'b1;
          end else begin
            stateNext      = ST_COUNT;
            strobe.loadCnt = 1'b1;
          end
        end
      end
      ST_COUNT: begin
        if (cntIsOne) begin
          if (waitSync) begin
            stateNext = ST_HOLD;
          end else begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!waitSync) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      accDone <= 1'b0;
    end else begin
      stateQ  <= stateNext;
      accDone <= doneNext;
    end
  end

  assign cpuStall = (stateQ != ST_IDLE);

endmodule

// File: rtl/xmem_wait_gen.sv
module xmem_wait_gen
  import xmem_wait_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 16,
  parameter int CODE_W      = 2,
  parameter int CODE_LSB    = 0,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'hC000,
  parameter logic [CODE_W-1:0] RST_CODE = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStart,
  output logic              cpuStall,
  output logic              accDone,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              waitPin
);

  ctrlStrobe_t strobe;
  logic isExt, loadZero, cntIsOne, waitSync;

  xmem_wait_dp #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
    .SYNC_STAGES(SYNC_STAGES), .EXT_BASE(EXT_BASE), .RST_CODE(RST_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .waitPin(waitPin), .strobe(strobe),
    .regQ(regRdData), .isExt(isExt), .loadZero(loadZero),
    .cntIsOne(cntIsOne), .waitSync(waitSync)
  );

  xmem_wait_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accStart(accStart), .isExt(isExt),
    .loadZero(loadZero), .cntIsOne(cntIsOne), .waitSync(waitSync),
    .strobe(strobe), .cpuStall(cpuStall), .accDone(accDone)
  );

endmodule

// File: rtl/xmem_wait_chk.sv
module xmem_wait_chk #(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 16,
  parameter int CODE_W   = 2,
  parameter int CODE_LSB = 0,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'hC000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] accAddr,
  input logic              accStart,
  input logic              cpuStall,
  input logic              accDone,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              isExt,
  input logic              waitSync
);

  logic [CODE_W-1:0] codeNow;
  assign codeNow = regRdData[CODE_LSB +: CODE_W];

  // R2: written value is visible after the write edge
  a_r2_reg_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == $past(regWrData)));

  // R3: internal access completes at once without stall
  a_r3_int_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (accStart && !cpuStall && (accAddr < EXT_BASE)) |=> (accDone && !cpuStall));

  // R4: zero-wait external access with wait idle completes at once
  a_r4_zero_wait: assert property (@(posedge clk) disable iff (!rstN)
    (accStart && !cpuStall && isExt && (codeNow == '0) && !waitSync)
      |=> (accDone && !cpuStall));

  // R6: no completion while synchronised wait holds a stalled access
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && waitSync) |=> !accDone);

  // R9: done and stall are exclusive
  a_r9_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(accDone && cpuStall));

endmodule

bind xmem_wait_gen xmem_wait_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
  .EXT_BASE(EXT_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .accAddr(accAddr), .accStart(accStart),
  .cpuStall(cpuStall), .accDone(accDone), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .isExt(isExt),
  .waitSync(waitSync)
);

// File: tb/xmem_wait_gen_tb_top.sv
module xmem_wait_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] accAddr;
  logic        accStart;
  logic        cpuStall;
  logic        accDone;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        waitPin;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int stalls, lat, dones;

  always #5 clk = ~clk;

  xmem_wait_gen dut_i (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accStart(accStart),
    .cpuStall(cpuStall), .accDone(accDone), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .waitPin(waitPin)
  );

  // {address, code, expected stall cycles}
  localparam int NVEC = 10;
  localparam logic [21:0] VEC [NVEC] = '{
    {16'hC000, 2'd0, 4'd0},
    {16'hC000, 2'd1, 4'd1},
    {16'hE123, 2'd2, 4'd3},
    {16'hFFFF, 2'd3, 4'd7},
    {16'hBFFF, 2'd3, 4'd0},
    {16'h0000, 2'd3, 4'd0},
    {16'h8000, 2'd2, 4'd0},
    {16'hFFFF, 2'd0, 4'd0},
    {16'hD000, 2'd1, 4'd1},
    {16'hC001, 2'd2, 4'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      finishRun();
    end
  end

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Start pulse; returns at the first sample after the start edge
  task automatic startAcc(input logic [15:0] a);
    @(negedge clk);
    accAddr = a; accStart = 1'b1;
    @(negedge clk);
    accStart = 1'b0;
  endtask

  // Run one access; stall count, done sample index (-1 on timeout)
  task automatic runAcc(input logic [15:0] a, output int st, output int lt);
    st = 0; lt = -1;
    startAcc(a);
    for (int i = 1; i <= 60; i++) begin
      if (accDone) begin lt = i; break; end
      if (cpuStall) st++;
      @(negedge clk);
    end
  endtask

  initial begin
    rstN = 1'b0; accAddr = '0; accStart = 1'b0;
    regWrEn = 1'b0; regWrData = '0; waitPin = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reg", int'(regRdData), 3);
    check("R1 stall", int'(cpuStall), 0);
    check("R1 done", int'(accDone), 0);
    rstN = 1'b1;
    // R1: default code gives 7 cycles
    runAcc(16'hF000, stalls, lat);
    check("R1 default stalls", stalls, 7);
    check("R1 default latency", lat, 8);

    // R2: full register write and readback
    writeReg(16'hA5F2);
    check("R2 readback", int'(regRdData), 16'hA5F2);

    // R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      writeReg({14'h2D5B, VEC[v][5:4]});
      runAcc(VEC[v][21:6], stalls, lat);
      check("R4/R5 vec stalls", stalls, int'(VEC[v][3:0]));
      check("R4/R5 vec latency", lat, int'(VEC[v][3:0]) + 1);
    end

    // R3: internal access ignores wait pin
    writeReg(16'h0003);
    waitPin = 1'b1;
    repeat (4) @(negedge clk);
    runAcc(16'hBFFF, stalls, lat);
    check("R3 int with wait stalls", stalls, 0);
    check("R3 int with wait latency", lat, 1);

    // R6: wait pin extends an external access
    writeReg(16'h0001);
    startAcc(16'hC000);
    dones = 0;
    for (int i = 0; i < 10; i++) begin
      if (accDone) dones++;
      if (!cpuStall) dones++;
      @(negedge clk);
    end
    check("R6 held by wait", dones, 0);
    waitPin = 1'b0;
    @(negedge clk);
    check("R6 stall after release 1", int'(cpuStall), 1);
    @(negedge clk);
    check("R6 stall after release 2", int'(cpuStall), 1);
    @(negedge clk);
    check("R6 done on third edge", int'(accDone), 1);

    // R7: start during stall ignored
    writeReg(16'h0003);
    startAcc(16'hC000);
    dones = 0; lat = -1;
    for (int i = 1; i <= 20; i++) begin
      if (i == 2) accStart = 1'b1;
      if (i == 3) accStart = 1'b0;
      if (i == 2) accAddr = 16'h1000;
      if (accDone) begin dones++; if (lat < 0) lat = i; end
      @(negedge clk);
    end
    check("R7 single done", dones, 1);
    check("R7 latency unchanged", lat, 8);

    // R8: register write during access affects only the next access
    startAcc(16'hC100);
    lat = -1;
    for (int i = 1; i <= 20; i++) begin
      if (i == 2) begin regWrEn = 1'b1; regWrData = 16'h0000; end
      if (i == 3) regWrEn = 1'b0;
      if (accDone && lat < 0) lat = i;
      @(negedge clk);
    end
    check("R8 current access length", lat, 8);
    runAcc(16'hC100, stalls, lat);
    check("R8 next access latency", lat, 1);

    // R9: done and stall never together across a long access
    writeReg(16'h0002);
    startAcc(16'hFFFF);
    dones = 0;
    for (int i = 0; i < 8; i++) begin
      if (accDone && cpuStall) dones++;
      @(negedge clk);
    end
    check("R9 exclusive", dones, 0);

    finishRun();
  end

endmodule